// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block gathers the interrupt requests of up to seven I/O functions onto one level-sensitive interrupt line toward the host. Each function's request is captured in a pending bit. That bit stays set until the host issues a clear for that function. The host can read all pending bits at once to find the sources. Several sources may be pending together. The block gives none of them priority, and the host decides the order in which to service them.

Two levels of gating decide whether pending requests reach the shared line. Each function has its own enable bit. A single master enable covers all functions. The host writes both kinds of enable through one byte-wide write port and reads them back on a read port. The enables affect only the shared line. The pending bits record requests whatever the enables hold.

Top module: `sdio_irq_aggregator`

## Requirements
- R1: After reset, the enable byte reads 0x00, the pending byte reads 0x00 and `irq_o` is low.
- R2: If `func_req[n-1]` is high at a clock edge, bit n of `pend_rdata` (n = 1..7) is set after that edge. Bit 0 of `pend_rdata` always reads 0.
- R3: A pending bit stays set after its request input falls, for as long as no clear is issued for it.
- R4: A high `clr[n]` at an edge clears pending bit n, and this takes priority over the request at that edge. If the request is still high at the following edge, the bit sets again. `clr[0]` has no effect.
- R5: An edge with `en_wr` high loads `en_wdata` into the enable byte. Bit 0 is the master enable and bit n (1..7) is function n's enable. `en_rdata` returns the stored byte.
- R6: `irq_o` is high exactly when the master enable is set and at least one function has both its pending bit and its enable bit set.
- R7: Pending bits are captured and held whatever the enable byte holds. Writing the enables leaves the pending byte unchanged.
- R8: Any combination of functions may be pending at once. Clearing some of them leaves the others pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_req | input | 7 | Request inputs; bit n-1 belongs to function n |
| en_wr | input | 1 | Write strobe for the enable byte |
| en_wdata | input | 8 | Enable byte to write; bit 0 is master, bit n is function n |
| clr | input | 8 | Clear commands; bit n clears function n's pending bit, bit 0 unused |
| en_rdata | output | 8 | Current enable byte |
| pend_rdata | output | 8 | Pending byte; bit n for function n, bit 0 zero |
| irq_o | output | 1 | Shared level-sensitive interrupt request |

## Verification
The properties that follow a request or a clear use the previous cycle's `func_req`, `clr` and `en_wdata`. They therefore assume these inputs are at rest, low and zero, while reset is asserted. This keeps the first cycle after reset consistent with the registers' reset values. The stimulus holds all inputs at zero through reset. It then changes them only just after a rising edge, so each value is stable for a full cycle before it is sampled. The sweep covers every request pattern, and for each pattern every enable byte.

// File: rtl/sdio_irq_aggregator.sv
module sdio_irq_aggregator #(
  parameter int NF = 7,
  localparam int RW = NF + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] func_req,
  input  logic          en_wr,
  input  logic [RW-1:0] en_wdata,
  input  logic [RW-1:0] clr,
  output logic [RW-1:0] en_rdata,
  output logic [RW-1:0] pend_rdata,
  output logic          irq_o
);

  logic [NF-1:0] pend_q;
  logic [NF-1:0] fen_q;
  logic          master_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q    <= '0;
      master_q <= 1'b0;
    end else if (en_wr) begin
      fen_q    <= en_wdata[RW-1:1];
      master_q <= en_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q | func_req) & ~clr[RW-1:1];
  end

  assign en_rdata   = {fen_q, master_q};
  assign pend_rdata = {pend_q, 1'b0};
  assign irq_o      = master_q & |(pend_q & fen_q);

endmodule

module sdio_irq_aggregator_chk #(
  parameter int NF = 7,
  localparam int RW = NF + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NF-1:0] func_req,
  input logic          en_wr,
  input logic [RW-1:0] en_wdata,
  input logic [RW-1:0] clr,
  input logic [RW-1:0] en_rdata,
  input logic [RW-1:0] pend_rdata,
  input logic          irq_o
);

  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rdata[0] == 1'b0); // R2
  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (({$past(func_req), 1'b0} & ~$past(clr) & ~pend_rdata) == '0)); // R2
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_rdata) & ~$past(clr) & ~pend_rdata) == '0)); // R3
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr[RW-1:1]) |=> (($past(clr) & pend_rdata & ~RW'(1)) == '0)); // R4
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_rdata == $past(en_wdata))); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_rdata)); // R5
  AST_IRQ_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_rdata[0]); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(pend_rdata & en_rdata & ~RW'(1))); // R6

endmodule

bind sdio_irq_aggregator sdio_irq_aggregator_chk #(.NF(NF)) u_chk (.*);

// File: tb/sdio_irq_aggregator_bench.sv
`timescale 1ns/1ps
module sdio_irq_aggregator_bench;
  localparam int NF = 7;
  localparam int RW = NF + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] func_req = '0;
  logic          en_wr = 1'b0;
  logic [RW-1:0] en_wdata = '0;
  logic [RW-1:0] clr = '0;
  logic [RW-1:0] en_rdata, pend_rdata;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdio_irq_aggregator #(.NF(NF)) u_sdio_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .func_req(func_req), .en_wr(en_wr),
    .en_wdata(en_wdata), .clr(clr), .en_rdata(en_rdata),
    .pend_rdata(pend_rdata), .irq_o(irq_o)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_en(logic [RW-1:0] v);
    en_wdata = v; en_wr = 1'b1; tick(); en_wr = 1'b0; en_wdata = '0;
  endtask

  task automatic clear(logic [RW-1:0] v);
    clr = v; tick(); clr = '0;
  endtask

  task automatic raise(logic [NF-1:0] p);
    func_req = p; tick(); func_req = '0;
  endtask

  function automatic logic exp_irq(logic [NF-1:0] p, logic [RW-1:0] e);
    return e[0] & |(p & e[RW-1:1]);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 en", en_rdata, 0);
    chk("R1 pend", pend_rdata, 0);
    chk("R1 irq", irq_o, 0);
    rst_n = 1'b1;
    tick();

    // R2/R3/R6/R7 sweep over every request pattern and every enable byte
    for (int p = 0; p < (1 << NF); p++) begin
      clear('1);
      raise(NF'(p));
      chk("R2 set", pend_rdata, {NF'(p), 1'b0});
      tick();
      chk("R3 sticky", pend_rdata, {NF'(p), 1'b0});
      for (int e = 0; e < (1 << RW); e++) begin
        wr_en(RW'(e));
        chk("R5 readback", en_rdata, e);
        chk("R6 irq", irq_o, exp_irq(NF'(p), RW'(e)));
        chk("R7 pend kept", pend_rdata, {NF'(p), 1'b0});
      end
    end

    // R4: clear wins over a held request, then re-sets
    wr_en('1);
    clear('1);
    func_req = NF'(7'h05);
    tick();
    chk("R4 pre", pend_rdata, 8'h0A);
    clr = 8'h02; tick();
    chk("R4 clr wins", pend_rdata, 8'h08);
    clr = '0; tick();
    chk("R4 reset again", pend_rdata, 8'h0A);
    func_req = '0; tick();
    clear(8'h01);
    chk("R4 clr0 no effect", pend_rdata, 8'h0A);
    clear(8'h02);
    chk("R4 after clr", pend_rdata, 8'h08);
    chk("R6 irq remaining", irq_o, 1);

    // R8: each single clear leaves the rest
    for (int n = 1; n <= NF; n++) begin
      clear('1);
      raise('1);
      clear(RW'(1) << n);
      chk("R8 others kept", pend_rdata, 8'hFE & ~(8'h1 << n));
    end
    clear('1);
    chk("R6 none pending", irq_o, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule